// File: doc/BRIEF.md
# NZVC Execute Unit

This block is the execute stage of a small two-register machine with a 16-bit word. Each cycle it can take one operation: an operation code, the value of the register selected for that operation, and a word-wide memory operand. It forms the result and decides whether the register file should be written. It also keeps a four-bit status register of negative (N), zero (Z), overflow (V) and carry (C). Every operation updates its own subset of these flags and leaves the others alone.

The unit covers arithmetic (add, subtract, negate), bitwise work (AND, OR, invert), an arithmetic right shift, loads of a full word or a single byte, and stores. A byte load replaces only the low byte of the register and keeps the high part. A store sends the register value out unchanged as the data to be written to memory. Addressing, memory access and register storage are handled by the surrounding pipeline. Results and flags are registered and appear one clock after the operation is presented.

Top module: `nzvc_exec_unit`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted operation, `result` is 0, `wr_en` is 0 and `flags` is 0. Flags are packed as `flags[3]`=N, `flags[2]`=Z, `flags[1]`=V, `flags[0]`=C.
- R2: An operation is accepted on a rising clock edge when `op_valid` is high. Its result and flags appear after that same edge. `wr_en` is high for exactly that one cycle for the codes ADD=0, SUB=1, AND=2, OR=3, INV=4, NEG=5, ASR=6, LDW=7 and LDB=8. It is low otherwise.
- R3: ADD gives `reg_val + mem_val` modulo 2^16. N is bit 15 of the result and Z is set when the result is zero. V marks signed overflow and C is the carry out of bit 15.
- R4: SUB gives `reg_val - mem_val` and sets N, Z and V as ADD does. C is the carry out of `reg_val + ~mem_val + 1`, so C=1 means no borrow.
- R5: AND and OR are bitwise on `reg_val` and `mem_val`. They update N and Z from the result and keep V and C.
- R6: INV gives the bitwise complement of `reg_val`, ignores `mem_val`, updates N and Z, and keeps V and C.
- R7: NEG gives the two's complement of `reg_val`. It updates N and Z, sets V exactly when `reg_val` is 0x8000, and keeps C.
- R8: ASR shifts `reg_val` right by one and keeps bit 15. The bit shifted out of bit 0 goes to C. N and Z are updated and V is kept.
- R9: LDW returns `mem_val`, ignores `reg_val`, updates N and Z, and keeps V and C.
- R10: LDB returns `reg_val[15:8]` joined with `mem_val[7:0]`. It updates N and Z from this merged word and keeps V and C.
- R11: STW=9 and STB=10 return `reg_val` unchanged on `result`, hold `wr_en` low and change no flag.
- R12: With `op_valid` low, or with codes 11 to 15, `result` and `flags` hold their values and `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (see R2, R11) |
| reg_val | input | 16 | Value of the selected register |
| mem_val | input | 16 | Memory operand |
| result | output | 16 | Registered result or store data |
| wr_en | output | 1 | Register write strobe for the accepted operation |
| flags | output | 4 | Status bits {N, Z, V, C} |

## Verification
The status register is the only state that lasts beyond one operation. A corrupted bit in it therefore stays hidden until a later operation either reads it through the kept-flag path or overwrites it. The bench sets V and C to known values before each operation that keeps them, so a wrong kept flag appears on `flags` one cycle after that operation. A wrong result or write strobe appears in the cycle right after the accepting edge. Idle and unknown-code cycles are checked so that any drift in the held state also shows up within a cycle.

// File: rtl/nzvc_exec_pkg.sv
package nzvc_exec_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_AND = 4'd2,
      OP_OR  = 4'd3,
      OP_INV = 4'd4,
      OP_NEG = 4'd5,
      OP_ASR = 4'd6,
      OP_LDW = 4'd7,
      OP_LDB = 4'd8,
      OP_STW = 4'd9,
      OP_STB = 4'd10
   } op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } nzvc_t;

   localparam int OP_BITS = 4;

endpackage

// File: rtl/nzvc_adder.sv
module nzvc_adder #(
   parameter int WIDTH  = 16,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             c_msb
);

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = a[i] ^ b[i] ^ carry[i];
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
         end
         assign cout  = carry[WIDTH];
         assign c_msb = carry[WIDTH-1];
      end else begin : g_behav
         logic [WIDTH-1:0] low;
         assign {cout, sum} = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
         assign low         = {1'b0, a[WIDTH-2:0]} + {1'b0, b[WIDTH-2:0]}
                              + {{(WIDTH-1){1'b0}}, cin};
         assign c_msb       = low[WIDTH-1];
      end
   endgenerate

endmodule

// File: rtl/nzvc_arith.sv
module nzvc_arith
   import nzvc_exec_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter bit RIPPLE = 1'b0
) (
   input  op_e              op,
   input  logic [WIDTH-1:0] reg_val,
   input  logic [WIDTH-1:0] mem_val,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);

   logic [WIDTH-1:0] opa;
   logic [WIDTH-1:0] opb;
   logic             ci;
   logic             carry_into_msb;

   // One shared adder: subtract and negate both add a complemented operand plus one
   always_comb begin
      case (op)
         OP_SUB: begin
            opa = reg_val;
            opb = ~mem_val;
            ci  = 1'b1;
         end
         OP_NEG: begin
            opa = '0;
            opb = ~reg_val;
            ci  = 1'b1;
         end
         default: begin
            opa = reg_val;
            opb = mem_val;
            ci  = 1'b0;
         end
      endcase
   end

   nzvc_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .a     (opa),
      .b     (opb),
      .cin   (ci),
      .sum   (sum),
      .cout  (cout),
      .c_msb (carry_into_msb)
   );

   assign ovf = carry_into_msb ^ cout;

endmodule

// File: rtl/nzvc_logic.sv
module nzvc_logic
   import nzvc_exec_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  op_e              op,
   input  logic [WIDTH-1:0] reg_val,
   input  logic [WIDTH-1:0] mem_val,
   output logic [WIDTH-1:0] res,
   output logic             shift_out
);

   always_comb begin
      case (op)
         OP_AND:  res = reg_val & mem_val;
         OP_OR:   res = reg_val | mem_val;
         OP_INV:  res = ~reg_val;
         OP_ASR:  res = {reg_val[WIDTH-1], reg_val[WIDTH-1:1]};
         default: res = reg_val;
      endcase
   end

   assign shift_out = reg_val[0];

endmodule

// File: rtl/nzvc_load.sv
module nzvc_load #(
   parameter int WIDTH  = 16,
   parameter int BYTE_W = 8
) (
   input  logic                    byte_mode,
   input  logic [WIDTH-1:BYTE_W]   reg_hi,
   input  logic [WIDTH-1:0]        mem_val,
   output logic [WIDTH-1:0]        res
);

   // Byte load keeps the upper register bits and replaces only the low byte
   assign res = byte_mode ? {reg_hi, mem_val[BYTE_W-1:0]} : mem_val;

endmodule

// File: rtl/nzvc_exec_unit.sv
module nzvc_exec_unit
   import nzvc_exec_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter int BYTE_W = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [3:0]       op_code,
   input  logic [WIDTH-1:0] reg_val,
   input  logic [WIDTH-1:0] mem_val,
   output logic [WIDTH-1:0] result,
   output logic             wr_en,
   output logic [3:0]       flags
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH <= BYTE_W) begin : g_bad_width
         $error("nzvc_exec_unit: WIDTH must exceed BYTE_W");
      end
      if (BYTE_W < 1) begin : g_bad_byte
         $error("nzvc_exec_unit: BYTE_W must be positive");
      end
   endgenerate

   op_e              op;
   nzvc_t            flags_q;
   nzvc_t            flags_d;
   logic [WIDTH-1:0] result_q;
   logic [WIDTH-1:0] res_d;
   logic             wr_q;
   logic             wr_d;
   logic             known_d;

   logic [WIDTH-1:0] ar_sum;
   logic             ar_cout;
   logic             ar_ovf;
   logic [WIDTH-1:0] lg_res;
   logic             lg_shift;
   logic [WIDTH-1:0] ld_res;

   assign op = op_e'(op_code);

   nzvc_arith #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_arith (
      .op      (op),
      .reg_val (reg_val),
      .mem_val (mem_val),
      .sum     (ar_sum),
      .cout    (ar_cout),
      .ovf     (ar_ovf)
   );

   nzvc_logic #(.WIDTH(WIDTH)) u_logic (
      .op        (op),
      .reg_val   (reg_val),
      .mem_val   (mem_val),
      .res       (lg_res),
      .shift_out (lg_shift)
   );

   nzvc_load #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_load (
      .byte_mode (op == OP_LDB),
      .reg_hi    (reg_val[MSB:BYTE_W]),
      .mem_val   (mem_val),
      .res       (ld_res)
   );

   // Select the result and the per-operation flag update
   always_comb begin
      res_d   = result_q;
      flags_d = flags_q;
      wr_d    = 1'b0;
      known_d = 1'b1;
      case (op)
         OP_ADD, OP_SUB: begin
            res_d     = ar_sum;
            wr_d      = 1'b1;
            flags_d.v = ar_ovf;
            flags_d.c = ar_cout;
         end
         OP_NEG: begin
            res_d     = ar_sum;
            wr_d      = 1'b1;
            flags_d.v = ar_ovf;
         end
         OP_AND, OP_OR, OP_INV: begin
            res_d = lg_res;
            wr_d  = 1'b1;
         end
         OP_ASR: begin
            res_d     = lg_res;
            wr_d      = 1'b1;
            flags_d.c = lg_shift;
         end
         OP_LDW, OP_LDB: begin
            res_d = ld_res;
            wr_d  = 1'b1;
         end
         OP_STW, OP_STB: begin
            res_d = reg_val;
         end
         default: begin
            known_d = 1'b0;
         end
      endcase
      if (wr_d) begin
         flags_d.n = res_d[MSB];
         flags_d.z = (res_d == '0);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_q <= '0;
         flags_q  <= '0;
         wr_q     <= 1'b0;
      end else begin
         wr_q <= op_valid & wr_d;
         if (op_valid && known_d) begin
            result_q <= res_d;
            flags_q  <= flags_d;
         end
      end
   end

   assign result = result_q;
   assign wr_en  = wr_q;
   assign flags  = flags_q;

endmodule

// File: rtl/nzvc_exec_checks.sv
module nzvc_exec_checks
   import nzvc_exec_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter int BYTE_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [3:0]       op_code,
   input logic [WIDTH-1:0] reg_val,
   input logic [WIDTH-1:0] mem_val,
   input logic [WIDTH-1:0] result,
   input logic             wr_en,
   input logic [3:0]       flags
);

   localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};

   assert_wr_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(op_valid) && ($past(op_code) <= 4'd8)));

   assert_add_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_valid) && $past(op_code) == OP_ADD)
      |-> (result == WIDTH'($past(reg_val) + $past(mem_val))));

   assert_nz_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_valid) && $past(op_code) <= 4'd8)
      |-> (flags[3] == result[WIDTH-1] && flags[2] == (result == '0)));

   assert_logic_keeps_vc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_valid) && ($past(op_code) == OP_AND || $past(op_code) == OP_OR
                           || $past(op_code) == OP_INV))
      |-> (flags[1:0] == $past(flags[1:0])));

   assert_neg_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_valid) && $past(op_code) == OP_NEG)
      |-> (flags[1] == ($past(reg_val) == MIN_NEG)));

   assert_byte_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_valid) && $past(op_code) == OP_LDB)
      |-> (result[WIDTH-1:BYTE_W] == $past(reg_val[WIDTH-1:BYTE_W])
           && result[BYTE_W-1:0] == $past(mem_val[BYTE_W-1:0])));

   assert_store_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_valid) && ($past(op_code) == OP_STW || $past(op_code) == OP_STB))
      |-> (result == $past(reg_val) && !wr_en && $stable(flags)));

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(op_valid) || $past(op_code) > 4'd10)
      |-> ($stable(result) && $stable(flags) && !wr_en));

endmodule

bind nzvc_exec_unit nzvc_exec_checks #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_checks (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_code  (op_code),
   .reg_val  (reg_val),
   .mem_val  (mem_val),
   .result   (result),
   .wr_en    (wr_en),
   .flags    (flags)
);

// File: tb/tb_nzvc_exec_unit.sv
`timescale 1ns/1ps
module tb_nzvc_exec_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = 4'd0;
   logic [15:0] reg_val = 16'h0;
   logic [15:0] mem_val = 16'h0;
   logic [15:0] result;
   logic        wr_en;
   logic [3:0]  flags;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   nzvc_exec_unit dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op_code  (op_code),
      .reg_val  (reg_val),
      .mem_val  (mem_val),
      .result   (result),
      .wr_en    (wr_en),
      .flags    (flags)
   );

   // Present one operation for one edge, then sample at the next falling edge
   task automatic run_op(input logic [3:0] op, input logic [15:0] r, input logic [15:0] m);
      @(negedge clk);
      op_valid = 1'b1;
      op_code  = op;
      reg_val  = r;
      mem_val  = m;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic expect_out(input string req, input logic [15:0] er,
                             input logic ew, input logic [3:0] ef);
      n_chk++;
      if (result !== er || wr_en !== ew || flags !== ef) begin
         n_fail++;
         $display("FAIL %s: result=%h wr_en=%b flags=%b, expected result=%h wr_en=%b flags=%b",
                  req, result, wr_en, flags, er, ew, ef);
      end
   endtask

   task automatic t_reset();
      expect_out("R1 reset", 16'h0000, 1'b0, 4'b0000);
   endtask

   task automatic t_add();
      run_op(4'd0, 16'h0005, 16'hFFF9);
      expect_out("R3 add negative sum", 16'hFFFE, 1'b1, 4'b1000);
      run_op(4'd0, 16'h7FFF, 16'h0001);
      expect_out("R3 add signed overflow", 16'h8000, 1'b1, 4'b1010);
      run_op(4'd0, 16'hFFFF, 16'h0001);
      expect_out("R3 add carry to zero", 16'h0000, 1'b1, 4'b0101);
      @(negedge clk);
      expect_out("R2 strobe one cycle", 16'h0000, 1'b0, 4'b0101);
   endtask

   task automatic t_sub();
      run_op(4'd1, 16'h0003, 16'h0009);
      expect_out("R4 sub with borrow", 16'hFFFA, 1'b1, 4'b1000);
      run_op(4'd1, 16'h0009, 16'h0003);
      expect_out("R4 sub no borrow", 16'h0006, 1'b1, 4'b0001);
      run_op(4'd1, 16'h8000, 16'h0001);
      expect_out("R4 sub signed overflow", 16'h7FFF, 1'b1, 4'b0011);
   endtask

   task automatic t_logic();
      run_op(4'd0, 16'h8000, 16'h8000);
      expect_out("R3 preset V and C", 16'h0000, 1'b1, 4'b0111);
      run_op(4'd2, 16'h5DC3, 16'h00FF);
      expect_out("R5 and keeps VC", 16'h00C3, 1'b1, 4'b0011);
      run_op(4'd3, 16'h5DC3, 16'h00FF);
      expect_out("R5 or keeps VC", 16'h5DFF, 1'b1, 4'b0011);
      run_op(4'd2, 16'h00FF, 16'hFF00);
      expect_out("R5 and zero", 16'h0000, 1'b1, 4'b0111);
      run_op(4'd4, 16'h0003, 16'h1234);
      expect_out("R6 invert", 16'hFFFC, 1'b1, 4'b1011);
   endtask

   task automatic t_neg();
      run_op(4'd0, 16'h0005, 16'hFFF9);
      expect_out("R3 clear V and C", 16'hFFFE, 1'b1, 4'b1000);
      run_op(4'd5, 16'h0003, 16'hAAAA);
      expect_out("R7 negate three", 16'hFFFD, 1'b1, 4'b1000);
      run_op(4'd0, 16'hFFFF, 16'h0001);
      expect_out("R3 preset C", 16'h0000, 1'b1, 4'b0101);
      run_op(4'd5, 16'h8000, 16'h0000);
      expect_out("R7 negate most negative", 16'h8000, 1'b1, 4'b1011);
      run_op(4'd5, 16'h0000, 16'h0000);
      expect_out("R7 negate zero keeps C", 16'h0000, 1'b1, 4'b0101);
   endtask

   task automatic t_asr();
      run_op(4'd6, 16'h8003, 16'h0000);
      expect_out("R8 asr sign kept", 16'hC001, 1'b1, 4'b1001);
      run_op(4'd6, 16'h0001, 16'hFFFF);
      expect_out("R8 asr to zero", 16'h0000, 1'b1, 4'b0101);
      run_op(4'd6, 16'h4000, 16'h0000);
      expect_out("R8 asr carry clear", 16'h2000, 1'b1, 4'b0000);
   endtask

   task automatic t_loads();
      run_op(4'd0, 16'h8000, 16'h8000);
      expect_out("R3 preset V and C", 16'h0000, 1'b1, 4'b0111);
      run_op(4'd7, 16'h1111, 16'h92EF);
      expect_out("R9 load word negative", 16'h92EF, 1'b1, 4'b1011);
      run_op(4'd7, 16'hFFFF, 16'h0000);
      expect_out("R9 load word zero", 16'h0000, 1'b1, 4'b0111);
      run_op(4'd8, 16'hABCD, 16'h1292);
      expect_out("R10 load byte merge", 16'hAB92, 1'b1, 4'b1011);
      run_op(4'd8, 16'h0034, 16'hFF00);
      expect_out("R10 load byte zero", 16'h0000, 1'b1, 4'b0111);
   endtask

   task automatic t_store_idle();
      run_op(4'd9, 16'h1234, 16'hFFFF);
      expect_out("R11 store word", 16'h1234, 1'b0, 4'b0111);
      run_op(4'd10, 16'h80FE, 16'h0000);
      expect_out("R11 store byte", 16'h80FE, 1'b0, 4'b0111);
      @(negedge clk);
      op_code = 4'd0; reg_val = 16'h0001; mem_val = 16'h0001;
      @(negedge clk);
      expect_out("R12 valid low", 16'h80FE, 1'b0, 4'b0111);
      run_op(4'd12, 16'h5555, 16'h5555);
      expect_out("R12 unknown code", 16'h80FE, 1'b0, 4'b0111);
      run_op(4'd15, 16'h0000, 16'h0000);
      expect_out("R12 code fifteen", 16'h80FE, 1'b0, 4'b0111);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_add();
      t_sub();
      t_logic();
      t_neg();
      t_asr();
      t_loads();
      t_store_idle();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      finish_run();
   end

endmodule